// File: doc/BRIEF.md
# Hall Commutation and Fault Controller

This block turns the three Hall sensor levels of a brushless motor, together with a rotation direction bit, into six gate requests for a three-phase MOSFET bridge. Each phase has one high-side request and one low-side request. Each of the six valid Hall codes selects one phase whose high side conducts and one phase whose low side conducts. When the PWM input is inactive, the high side is released and the current recirculates through the low sides. A decay-mode input chooses the recirculation pattern.

Above the running path sit a set of overrides: a dynamic brake request, a disable input, undervoltage and overtemperature flags, and an illegal-code detector. The brake-or-coast choice used by the disable input and by the undervoltage flag is sampled when disable rises. Per-phase drain-source-high flags report a motor lead shorted to ground. The block latches that fault and drops all high-side requests. The latch is released at the next commutation step, on either edge of disable, or by reset. A registered fault output reports every active condition. The analog comparators and gate drivers sit outside the block.

Top module: `hall_commutator`

## Requirements
- R1: With `dir_fwd`=1 the Hall code {H1,H2,H3} = `hall_in[2:0]` selects the high phase and the low phase as follows (phase bits 0=A, 1=B, 2=C): 101 A/C, 100 B/C, 110 B/A, 010 C/A, 011 C/B, 001 A/B. Hall inputs pass two synchronizer flops, and the gate outputs are registered, so a Hall change appears at the outputs on the third rising edge. Every other input appears on the first rising edge.
- R2: With `dir_fwd`=0 every code selects the same two phases with their roles exchanged. For example, 101 gives C high and A low.
- R3: Hall codes 000 and 111 are illegal. They clear all six gate outputs and raise `fault`.
- R4: With `pwm_on`=0 and `decay_slow`=0 (fast decay), the high side goes off, the selected low side goes off, and the low side of the phase that was driven high turns on.
- R5: With `pwm_on`=0 and `decay_slow`=1 (slow decay), the high side goes off, and both the selected low side and the low side of the phase that was driven high are on. With `pwm_on`=1, `decay_slow` has no effect.
- R6: `brake_req`=1 turns all three low sides on and all high sides off, without raising `fault`.
- R7: `disable_in`=1 turns all high sides off. All three low sides then follow the value of `stop_brake_sel` captured in the cycle where `disable_in` rises (1 = all on, 0 = all off). Changes of `stop_brake_sel` while disable stays high have no effect. Disable overrides `brake_req`.
- R8: `uv_flag`=1 raises `fault` and drives all low sides from the captured select, with all high sides off. The captured select is 0 (coast) after reset.
- R9: `ot_flag`=1 raises `fault` and turns all six outputs off. The priority is: disable, then overtemperature, then undervoltage, then illegal code, then brake, then normal running.
- R10: A `ds_high` bit set on the phase whose high-side output is on latches a short fault. The latch forces all high sides off, leaves the low sides unchanged, and keeps `fault` high after the flag drops. A `ds_high` bit on a phase whose high side is off is ignored.
- R11: The short latch clears when the synchronized Hall code changes, on either edge of `disable_in`, and on reset. A clear in the same cycle as a new short indication wins.
- R12: The high and low outputs of a phase are never on together, and at most one high-side output is on.
- R13: During and directly after reset all gate outputs and `fault` are 0. `fault` is the registered OR of the active fault conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| hall_in | input | 3 | Hall levels {H1,H2,H3}, asynchronous |
| dir_fwd | input | 1 | Rotation direction select |
| pwm_on | input | 1 | 1 = selected bridge path conducts, 0 = recirculate |
| decay_slow | input | 1 | Recirculation pattern: 1 slow, 0 fast |
| brake_req | input | 1 | Dynamic brake request |
| stop_brake_sel | input | 1 | Brake (1) or coast (0) choice for disable and undervoltage |
| disable_in | input | 1 | Bridge disable, also clears the short latch on each edge |
| uv_flag | input | 1 | Supply undervoltage indication |
| ot_flag | input | 1 | Overtemperature indication |
| ds_high | input | 3 | Per-phase high-side drain-source-high indication |
| gate_hi | output | 3 | High-side gate requests, bit 0 = phase A |
| gate_lo | output | 3 | Low-side gate requests, bit 0 = phase A |
| fault | output | 1 | Registered fault indication |

## Verification
On every cycle, the assertions watch the safety relations: no phase has both of its transistors on, there is never more than one high side, and disable removes all high sides. They also check that overtemperature coasts the bridge, that an unobstructed brake request sets all lows, that an illegal code raises the fault, and that a short indication against a live high side drops the highs. Only the bench's scenarios can show the content of each step table, the two decay patterns, which select value the disable edge captured, and that the short latch persists and is released by each of its clearing events.

// File: rtl/hcf_pkg.sv
package hcf_pkg;

    localparam int PHASES    = 3;
    localparam int HALL_BITS = 3;
    localparam int PH_IDX_W  = $clog2(PHASES);

    typedef logic [PHASES-1:0]    phase_vec_t;
    typedef logic [HALL_BITS-1:0] hall_code_t;
    typedef logic [PH_IDX_W-1:0]  phase_idx_t;

    // One commutation step: which phase sources and which phase sinks.
    typedef struct packed {
        logic       valid;
        phase_idx_t src_ph;
        phase_idx_t snk_ph;
    } step_t;

    typedef struct packed {
        phase_vec_t hi;
        phase_vec_t lo;
    } gate_t;

    typedef enum logic [2:0] {
        DRV_RUN,
        DRV_BRAKE,
        DRV_COAST,
        DRV_STORED
    } drive_mode_t;

    localparam phase_idx_t PH_A = phase_idx_t'(0);
    localparam phase_idx_t PH_B = phase_idx_t'(1);
    localparam phase_idx_t PH_C = phase_idx_t'(2);

    function automatic phase_vec_t ph_bit(input phase_idx_t p);
        return phase_vec_t'(1) << p;
    endfunction

    function automatic step_t mk_step(input phase_idx_t s, input phase_idx_t k);
        step_t r;
        r.valid  = 1'b1;
        r.src_ph = s;
        r.snk_ph = k;
        return r;
    endfunction

    // Forward rotation table; reverse is the same pair with roles swapped.
    function automatic step_t fwd_step(input hall_code_t code);
        step_t r;
        r = '0;
        case (code)
            3'b101:  r = mk_step(PH_A, PH_C);
            3'b100:  r = mk_step(PH_B, PH_C);
            3'b110:  r = mk_step(PH_B, PH_A);
            3'b010:  r = mk_step(PH_C, PH_A);
            3'b011:  r = mk_step(PH_C, PH_B);
            3'b001:  r = mk_step(PH_A, PH_B);
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hcf_sync.sv
module hcf_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/hcf_step_decode.sv
module hcf_step_decode
    import hcf_pkg::*;
(
    input  hall_code_t code,
    input  logic       dir_fwd,
    output step_t      step
);

    step_t base;

    always_comb begin
        base = fwd_step(code);
        step = base;
        if (!dir_fwd) begin
            step.src_ph = base.snk_ph;
            step.snk_ph = base.src_ph;
        end
    end

endmodule

// File: rtl/hcf_fault_unit.sv
module hcf_fault_unit
    import hcf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       illegal,
    input  logic       uv_flag,
    input  logic       ot_flag,
    input  phase_vec_t ds_high,
    input  phase_vec_t gate_hi_q,
    input  logic       step_change,
    input  logic       disable_in,
    input  logic       sel_in,
    output logic       short_now,
    output logic       sel_eff,
    output logic       fault_q
);

    logic dis_q;
    logic sel_q;
    logic short_q;
    logic dis_rise;
    logic dis_edge;
    logic short_set;
    logic short_clr;

    always_comb begin
        dis_rise  = disable_in & ~dis_q;
        dis_edge  = disable_in ^ dis_q;
        short_set = |(ds_high & gate_hi_q);
        short_clr = step_change | dis_edge;
        short_now = short_clr ? 1'b0 : (short_q | short_set);
        sel_eff   = dis_rise ? sel_in : sel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q   <= 1'b0;
            sel_q   <= 1'b0;
            short_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            dis_q   <= disable_in;
            sel_q   <= sel_eff;
            short_q <= short_now;
            fault_q <= illegal | uv_flag | ot_flag | short_now;
        end
    end

endmodule

// File: rtl/hcf_gate_mux.sv
module hcf_gate_mux
    import hcf_pkg::*;
(
    input  step_t  step,
    input  logic   pwm_on,
    input  logic   decay_slow,
    input  logic   brake_req,
    input  logic   disable_in,
    input  logic   uv_flag,
    input  logic   ot_flag,
    input  logic   short_now,
    input  logic   sel_eff,
    output gate_t  gate_nxt
);

    drive_mode_t mode;
    phase_vec_t  src_m;
    phase_vec_t  snk_m;

    always_comb begin
        if (disable_in)       mode = DRV_STORED;
        else if (ot_flag)     mode = DRV_COAST;
        else if (uv_flag)     mode = DRV_STORED;
        else if (!step.valid) mode = DRV_COAST;
        else if (brake_req)   mode = DRV_BRAKE;
        else                  mode = DRV_RUN;
    end

    always_comb begin
        src_m    = ph_bit(step.src_ph);
        snk_m    = ph_bit(step.snk_ph);
        gate_nxt = '0;
        case (mode)
            DRV_STORED: gate_nxt.lo = {PHASES{sel_eff}};
            DRV_BRAKE:  gate_nxt.lo = '1;
            DRV_RUN: begin
                if (pwm_on) begin
                    gate_nxt.hi = src_m;
                    gate_nxt.lo = snk_m;
                end else begin
                    gate_nxt.lo = src_m | (decay_slow ? snk_m : '0);
                end
                if (short_now) gate_nxt.hi = '0;
            end
            default:    gate_nxt = '0;
        endcase
    end

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hcf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] hall_in,
    input  logic       dir_fwd,
    input  logic       pwm_on,
    input  logic       decay_slow,
    input  logic       brake_req,
    input  logic       stop_brake_sel,
    input  logic       disable_in,
    input  logic       uv_flag,
    input  logic       ot_flag,
    input  logic [2:0] ds_high,
    output logic [2:0] gate_hi,
    output logic [2:0] gate_lo,
    output logic       fault
);

    hall_code_t hall_s;
    hall_code_t hall_prev;
    step_t      step;
    gate_t      gate_nxt;
    gate_t      gate_q;
    logic       step_change;
    logic       short_now;
    logic       sel_eff;
    logic       fault_q;

    hcf_sync #(
        .WIDTH  (HALL_BITS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (hall_in),
        .d_out (hall_s)
    );

    hcf_step_decode u_decode (
        .code    (hall_s),
        .dir_fwd (dir_fwd),
        .step    (step)
    );

    always_ff @(posedge clk) begin
        if (rst) hall_prev <= '0;
        else     hall_prev <= hall_s;
    end

    assign step_change = (hall_s != hall_prev);

    hcf_fault_unit u_fault (
        .clk         (clk),
        .rst         (rst),
        .illegal     (~step.valid),
        .uv_flag     (uv_flag),
        .ot_flag     (ot_flag),
        .ds_high     (ds_high),
        .gate_hi_q   (gate_q.hi),
        .step_change (step_change),
        .disable_in  (disable_in),
        .sel_in      (stop_brake_sel),
        .short_now   (short_now),
        .sel_eff     (sel_eff),
        .fault_q     (fault_q)
    );

    hcf_gate_mux u_mux (
        .step       (step),
        .pwm_on     (pwm_on),
        .decay_slow (decay_slow),
        .brake_req  (brake_req),
        .disable_in (disable_in),
        .uv_flag    (uv_flag),
        .ot_flag    (ot_flag),
        .short_now  (short_now),
        .sel_eff    (sel_eff),
        .gate_nxt   (gate_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) gate_q <= '0;
        else     gate_q <= gate_nxt;
    end

    assign gate_hi = gate_q.hi;
    assign gate_lo = gate_q.lo;
    assign fault   = fault_q;

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (gate_hi & gate_lo) == 3'b000); // R12

    AST_SINGLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        $countones(gate_hi) <= 1); // R12

    AST_DISABLE_HIGHS_OFF: assert property (@(posedge clk) disable iff (rst)
        disable_in |=> gate_hi == 3'b000); // R7

    AST_OT_COAST: assert property (@(posedge clk) disable iff (rst)
        (ot_flag && !disable_in) |=> (gate_hi == 3'b000 && gate_lo == 3'b000 && fault)); // R9

    AST_ILLEGAL_FAULT: assert property (@(posedge clk) disable iff (rst)
        !step.valid |=> fault); // R3

    AST_BRAKE_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        (brake_req && !disable_in && !ot_flag && !uv_flag && step.valid)
        |=> (gate_lo == 3'b111 && gate_hi == 3'b000)); // R6

    AST_SHORT_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
        ((|(ds_high & gate_hi)) && !step_change) |=> gate_hi == 3'b000); // R10

endmodule

// File: tb/test_hall_commutator.sv
module test_hall_commutator;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hall_in;
    logic       dir_fwd, pwm_on, decay_slow, brake_req, stop_brake_sel;
    logic       disable_in, uv_flag, ot_flag;
    logic [2:0] ds_high;
    logic [2:0] gate_hi, gate_lo;
    logic       fault;

    always #2 clk = ~clk;

    hall_commutator i_hall_commutator (
        .clk            (clk),
        .rst            (rst),
        .hall_in        (hall_in),
        .dir_fwd        (dir_fwd),
        .pwm_on         (pwm_on),
        .decay_slow     (decay_slow),
        .brake_req      (brake_req),
        .stop_brake_sel (stop_brake_sel),
        .disable_in     (disable_in),
        .uv_flag        (uv_flag),
        .ot_flag        (ot_flag),
        .ds_high        (ds_high),
        .gate_hi        (gate_hi),
        .gate_lo        (gate_lo),
        .fault          (fault)
    );

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        logic       flt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    event exp_ev;
    event chk_done;
    int   checks   = 0;
    int   failures = 0;
    bit   finished = 0;

    task automatic check_val(input string tag, input string what,
                             input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Monitor: pops one expected item per request and compares at a falling edge.
    initial begin : monitor
        forever begin
            exp_t e;
            @(exp_ev);
            @(negedge clk);
            e = exp_q.pop_front();
            check_val(e.tag, "gate_hi", gate_hi, e.hi);
            check_val(e.tag, "gate_lo", gate_lo, e.lo);
            check_val(e.tag, "fault", {2'b00, fault}, {2'b00, e.flt});
            check_val("R12", "hi_and_lo", gate_hi & gate_lo, 3'b000);
            ->chk_done;
        end
    end

    // Driver: lets the inputs settle, then queues the expected outputs.
    task automatic apply(input logic [2:0] hi, input logic [2:0] lo,
                         input logic flt, input string tag);
        exp_t e;
        repeat (4) @(posedge clk);
        e.hi  = hi;
        e.lo  = lo;
        e.flt = flt;
        e.tag = tag;
        exp_q.push_back(e);
        ->exp_ev;
        @(chk_done);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin : main
        rst = 1'b1; hall_in = 3'b101; dir_fwd = 1'b1; pwm_on = 1'b1; decay_slow = 1'b0;
        brake_req = 1'b0; stop_brake_sel = 1'b0; disable_in = 1'b0;
        uv_flag = 1'b0; ot_flag = 1'b0; ds_high = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R13", "gate_hi", gate_hi, 3'b000);
        check_val("R13", "gate_lo", gate_lo, 3'b000);
        check_val("R13", "fault", {2'b00, fault}, 3'b000);
        rst = 1'b0;

        // R1 forward table
        hall_in = 3'b101; apply(3'b001, 3'b100, 1'b0, "R1");
        hall_in = 3'b100; apply(3'b010, 3'b100, 1'b0, "R1");
        hall_in = 3'b110; apply(3'b010, 3'b001, 1'b0, "R1");
        hall_in = 3'b010; apply(3'b100, 3'b001, 1'b0, "R1");
        hall_in = 3'b011; apply(3'b100, 3'b010, 1'b0, "R1");
        hall_in = 3'b001; apply(3'b001, 3'b010, 1'b0, "R1");

        // R2 reverse table
        dir_fwd = 1'b0;
        hall_in = 3'b101; apply(3'b100, 3'b001, 1'b0, "R2");
        hall_in = 3'b100; apply(3'b100, 3'b010, 1'b0, "R2");
        hall_in = 3'b110; apply(3'b001, 3'b010, 1'b0, "R2");
        hall_in = 3'b010; apply(3'b001, 3'b100, 1'b0, "R2");
        hall_in = 3'b011; apply(3'b010, 3'b100, 1'b0, "R2");
        hall_in = 3'b001; apply(3'b010, 3'b001, 1'b0, "R2");
        dir_fwd = 1'b1;

        // R3 illegal codes
        hall_in = 3'b000; apply(3'b000, 3'b000, 1'b1, "R3");
        hall_in = 3'b111; apply(3'b000, 3'b000, 1'b1, "R3");

        // R4 / R5 decay patterns on step A high, C low
        hall_in = 3'b101; pwm_on = 1'b0; decay_slow = 1'b0;
        apply(3'b000, 3'b001, 1'b0, "R4");
        decay_slow = 1'b1; apply(3'b000, 3'b101, 1'b0, "R5");
        pwm_on = 1'b1;     apply(3'b001, 3'b100, 1'b0, "R5");
        decay_slow = 1'b0;

        // R6 brake, and R9 illegal code beating brake
        brake_req = 1'b1;  apply(3'b000, 3'b111, 1'b0, "R6");
        hall_in = 3'b111;  apply(3'b000, 3'b000, 1'b1, "R9");
        hall_in = 3'b101;

        // R7 disable with captured select, brake still requested
        stop_brake_sel = 1'b1; disable_in = 1'b1; apply(3'b000, 3'b111, 1'b0, "R7");
        stop_brake_sel = 1'b0; apply(3'b000, 3'b111, 1'b0, "R7");
        disable_in = 1'b0; brake_req = 1'b0; apply(3'b001, 3'b100, 1'b0, "R7");
        brake_req = 1'b1; disable_in = 1'b1; apply(3'b000, 3'b000, 1'b0, "R7");
        disable_in = 1'b0; brake_req = 1'b0; apply(3'b001, 3'b100, 1'b0, "R7");

        // R8 undervoltage with coast, then with brake captured
        uv_flag = 1'b1; apply(3'b000, 3'b000, 1'b1, "R8");
        uv_flag = 1'b0; stop_brake_sel = 1'b1; disable_in = 1'b1;
        apply(3'b000, 3'b111, 1'b0, "R8");
        disable_in = 1'b0; stop_brake_sel = 1'b0; apply(3'b001, 3'b100, 1'b0, "R8");
        uv_flag = 1'b1; apply(3'b000, 3'b111, 1'b1, "R8");

        // R9 overtemperature coasts even with undervoltage braking selected
        ot_flag = 1'b1; apply(3'b000, 3'b000, 1'b1, "R9");
        uv_flag = 1'b0; apply(3'b000, 3'b000, 1'b1, "R9");
        ot_flag = 1'b0; apply(3'b001, 3'b100, 1'b0, "R9");

        // R10 short on the live high side, latch holds after flag drops
        ds_high = 3'b001; apply(3'b000, 3'b100, 1'b1, "R10");
        ds_high = 3'b000; apply(3'b000, 3'b100, 1'b1, "R10");
        // R11 step change clears
        hall_in = 3'b100; apply(3'b010, 3'b100, 1'b0, "R11");
        // R10 flag on a phase without live high side is ignored
        ds_high = 3'b001; apply(3'b010, 3'b100, 1'b0, "R10");
        ds_high = 3'b000;

        // R11 disable toggle clears (select captured as 0)
        ds_high = 3'b010; apply(3'b000, 3'b100, 1'b1, "R11");
        ds_high = 3'b000; disable_in = 1'b1; apply(3'b000, 3'b000, 1'b0, "R11");
        disable_in = 1'b0; apply(3'b010, 3'b100, 1'b0, "R11");

        // R11 reset clears
        ds_high = 3'b010; apply(3'b000, 3'b100, 1'b1, "R11");
        ds_high = 3'b000;
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        apply(3'b010, 3'b100, 1'b0, "R11");

        finish_run();
    end

endmodule